// File: doc/BRIEF.md
# I2C slave address matcher

This block is the address-recognition front end of an I2C slave. It works on SCL and SDA levels that are already synchronised to the system clock. It finds bus events by comparing each line with its value one clock earlier. After a START it shifts in one byte, most significant bit first, sampling on each SCL rising edge. On the falling edge of the eighth SCL pulse it compares that byte with a software-written address register. If the address matches and the block is free to take it, the block copies the byte into a receive buffer, raises a buffer-full flag, and pulls SDA low through the ninth clock as ACK. It raises its interrupt flag when the ninth pulse falls.

In 10-bit mode, recognition takes two steps and uses the same address register for both. The header byte is checked first, and the low byte after it. After each of these two steps the block raises an update-address flag and holds SCL low. It keeps SCL low until software rewrites the address register with the value needed for the next step. After the full address has matched, a repeated START followed by the header with the read bit set is accepted directly. No clock stretch follows that byte. Software drains the buffer with a read strobe and clears the interrupt flag and the overflow flag separately.

Top module: `i2c_addr_match`

## Requirements
- R1: While `enable` is low, the block does the following. It holds `sda_pull`, `scl_hold`, `upd_addr`, `buf_full`, `ovf` and `irq` at 0 and ignores all bus activity. After reset all outputs are 0.
- R2: In 7-bit mode (`ten_bit`=0), the received byte matches when its bits 7:1 equal bits 7:1 of the address register. Bit 0 (R/W) is ignored in the comparison. On an accepted match, the block does three things from the eighth SCL falling edge: `rx_buf` takes the whole byte, `buf_full` rises, and `sda_pull` is high until the ninth SCL falling edge.
- R3: `irq` rises on the ninth SCL falling edge of an accepted byte and stays high until `irq_clr` is pulsed.
- R4: A byte that does not match gives no ACK and leaves `buf_full`, `irq` and `rx_buf` unchanged.
- R5: A byte that matches while `buf_full` or `ovf` is set is refused. `ovf` is set, `rx_buf` keeps its old value and SDA is left released (NACK).
- R6: A pulse on `buf_rd` clears `buf_full`, and a pulse on `ovf_clr` clears `ovf`.
- R7: In 10-bit mode the first byte is a header of the form 11110, A9, A8, R/W. The block accepts it only when R/W is 0 and bits 7:1 equal those of the address register. After the ninth falling edge, `upd_addr` and `scl_hold` are set along with `irq`.
- R8: A write to the address register during the hold clears `upd_addr` and `scl_hold`. The next byte is then compared with all eight bits of the address register.
- R9: An accepted 10-bit low byte sets `irq`, `buf_full`, `upd_addr` and `scl_hold` again. The next address write releases the hold.
- R10: Once both 10-bit bytes have matched, a repeated START followed by the header with R/W=1 is accepted. It sets `irq` and `buf_full` and leaves `upd_addr` and `scl_hold` at 0.
- R11: A STOP returns the block to idle and clears any 10-bit progress. After a STOP, a read header (R/W=1) gets no ACK until the whole write-header and low-byte sequence has been repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces idle and clears flags |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| addr_wr | input | 1 | Write strobe for the address register |
| addr_wdata | input | 8 | Value written to the address register |
| buf_rd | input | 1 | Receive-buffer read strobe, clears buffer-full |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| sda_pull | output | 1 | Open-drain pull-low enable for SDA |
| scl_hold | output | 1 | Open-drain pull-low enable for SCL (clock stretch) |
| rx_buf | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer-full flag |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt flag |
| upd_addr | output | 1 | Address register must be rewritten |

## Verification
Most internal faults in this block show at the ports within one bus bit time. A wrong bit count or a wrong compare shows at the eighth SCL falling edge as a missing or extra pull on SDA. A wrong 10-bit phase register stays hidden for longer. It shows only one byte later, as a refused low byte or a read header that is wrongly accepted after a STOP. For that reason the bench runs full two-byte sequences and sends a read header after each STOP. Flag bookkeeping faults appear at the ninth falling edge, or in the cycle after a clear strobe.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  localparam int BYTE_W = 8;
  localparam int HDR_W  = 5;
  localparam logic [HDR_W-1:0] HDR10 = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } am_state_t;

  typedef enum logic [1:0] {
    PH_HI,
    PH_LO,
    PH_DONE
  } am_phase_t;

  // upper seven bits agree; the direction bit is not compared
  function automatic logic top7_eq(input logic [BYTE_W-1:0] a,
                                   input logic [BYTE_W-1:0] b);
    return a[BYTE_W-1:1] == b[BYTE_W-1:1];
  endfunction

  // byte carries the 10-bit header prefix
  function automatic logic is_hdr(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: HDR_W] == HDR10;
  endfunction

endpackage

// File: rtl/i2c_am_events.sv
module i2c_am_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign bus_start = scl_in & scl_q & sda_q & ~sda_in;
  assign bus_stop  = scl_in & scl_q & ~sda_q & sda_in;

endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         rise,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         full
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
    end else if (clr) begin
      cnt  <= '0;
      data <= '0;
    end else if (en && rise && cnt != LAST) begin
      data <= {data[W-2:0], bit_in};
      cnt  <= cnt + 1'b1;
    end
  end

  assign full = (cnt == LAST);

endmodule

// File: rtl/i2c_am_decide.sv
module i2c_am_decide
  import i2c_am_pkg::*;
(
  input  logic              ten_bit,
  input  am_phase_t         phase,
  input  logic [BYTE_W-1:0] rx,
  input  logic [BYTE_W-1:0] own,
  output logic              hit,
  output logic              want_upd,
  output am_phase_t         ph_next
);

  logic hdr_ok, hdr_wr, hdr_rd;

  assign hdr_ok = is_hdr(rx) && top7_eq(rx, own);
  assign hdr_wr = hdr_ok && !rx[0];
  assign hdr_rd = hdr_ok && rx[0];

  always_comb begin
    hit      = 1'b0;
    want_upd = 1'b0;
    ph_next  = phase;
    if (!ten_bit) begin
      hit     = top7_eq(rx, own);
      ph_next = PH_HI;
    end else begin
      unique case (phase)
        PH_LO: begin
          hit      = (rx == own);
          want_upd = 1'b1;
          ph_next  = PH_DONE;
        end
        PH_DONE: begin
          if (hdr_rd) begin
            hit = 1'b1;
          end else if (hdr_wr) begin
            hit      = 1'b1;
            want_upd = 1'b1;
            ph_next  = PH_LO;
          end
        end
        default: begin
          hit      = hdr_wr;
          want_upd = 1'b1;
          ph_next  = PH_LO;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ten_bit,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_wr,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic              sda_pull,
  output logic              scl_hold,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq,
  output logic              upd_addr
);

  am_state_t         st;
  am_phase_t         ph, ph_nxt_q, ph_calc;
  logic [BYTE_W-1:0] own_addr, shreg;
  logic              upd_q, upd_calc, hit;
  logic              scl_rise, scl_fall, ev_start, ev_stop;
  logic              sh_full, sh_clr;
  logic              ev_byte, ev_take, ev_refuse;

  i2c_am_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  assign sh_clr = !enable || ev_start || (st == ST_HOLD && addr_wr);

  i2c_am_shifter #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .en(st == ST_SHIFT),
    .rise(scl_rise), .bit_in(sda_in), .data(shreg), .full(sh_full)
  );

  i2c_am_decide u_dec (
    .ten_bit(ten_bit), .phase(ph), .rx(shreg), .own(own_addr),
    .hit(hit), .want_upd(upd_calc), .ph_next(ph_calc)
  );

  // named events for the checker
  assign ev_byte   = enable && !ev_start && !ev_stop &&
                     st == ST_SHIFT && scl_fall && sh_full;
  assign ev_take   = ev_byte && hit && !buf_full && !ovf;
  assign ev_refuse = ev_byte && hit && (buf_full || ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_HI;
      ph_nxt_q <= PH_HI;
      upd_q    <= 1'b0;
      own_addr <= '0;
      rx_buf   <= '0;
      sda_pull <= 1'b0;
      scl_hold <= 1'b0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
      upd_addr <= 1'b0;
    end else begin
      if (addr_wr) own_addr <= addr_wdata;
      if (buf_rd)  buf_full <= 1'b0;
      if (irq_clr) irq      <= 1'b0;
      if (ovf_clr) ovf      <= 1'b0;

      if (!enable) begin
        st       <= ST_IDLE;
        ph       <= PH_HI;
        sda_pull <= 1'b0;
        scl_hold <= 1'b0;
        upd_addr <= 1'b0;
        buf_full <= 1'b0;
        ovf      <= 1'b0;
        irq      <= 1'b0;
      end else if (ev_stop) begin
        st       <= ST_IDLE;
        ph       <= PH_HI;
        sda_pull <= 1'b0;
        scl_hold <= 1'b0;
        upd_addr <= 1'b0;
      end else if (ev_start) begin
        st       <= ST_SHIFT;
        sda_pull <= 1'b0;
        scl_hold <= 1'b0;
        upd_addr <= 1'b0;
        if (ph != PH_DONE) ph <= PH_HI;
      end else begin
        unique case (st)
          ST_SHIFT: begin
            if (ev_take) begin
              rx_buf   <= shreg;
              buf_full <= 1'b1;
              sda_pull <= 1'b1;
              upd_q    <= upd_calc;
              ph_nxt_q <= ph_calc;
              st       <= ST_ACK;
            end else if (ev_refuse) begin
              ovf <= 1'b1;
              st  <= ST_SKIP;
            end else if (ev_byte) begin
              st <= ST_SKIP;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              irq      <= 1'b1;
              ph       <= ph_nxt_q;
              if (upd_q) begin
                upd_addr <= 1'b1;
                scl_hold <= 1'b1;
                st       <= ST_HOLD;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_HOLD: begin
            if (addr_wr) begin
              upd_addr <= 1'b0;
              scl_hold <= 1'b0;
              st       <= (ph == PH_LO) ? ST_SHIFT : ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk
  import i2c_am_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              buf_rd,
  input logic              addr_wr,
  input logic              ev_stop,
  input logic              ev_take,
  input logic              ev_refuse,
  input logic              sda_pull,
  input logic              scl_hold,
  input logic              upd_addr,
  input logic              buf_full,
  input logic              ovf,
  input logic [BYTE_W-1:0] rx_buf
);

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sda_pull && !scl_hold && !buf_full && !ovf);

  // R2
  take_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> buf_full && sda_pull);

  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse && enable |=> ovf && !sda_pull && $stable(rx_buf));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd && !ev_take |=> !buf_full);

  // R7
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> upd_addr);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && addr_wr && enable |=> !scl_hold && !upd_addr);

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && enable |=> !sda_pull && !scl_hold);

endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .buf_rd(buf_rd),
  .addr_wr(addr_wr), .ev_stop(ev_stop), .ev_take(ev_take),
  .ev_refuse(ev_refuse), .sda_pull(sda_pull), .scl_hold(scl_hold),
  .upd_addr(upd_addr), .buf_full(buf_full), .ovf(ovf), .rx_buf(rx_buf)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;

  localparam int CLK_P = 10;
  localparam int H     = 4;

  logic       clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ten_bit = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       addr_wr = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] addr_wdata = '0;
  logic       scl_in, sda_in, sda_pull, scl_hold, buf_full, ovf, irq, upd_addr;
  logic [7:0] rx_buf;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  assign scl_in = scl_m;
  assign sda_in = sda_m & ~sda_pull;

  always #(CLK_P/2) clk = ~clk;

  i2c_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ten_bit(ten_bit),
    .scl_in(scl_in), .sda_in(sda_in), .addr_wr(addr_wr),
    .addr_wdata(addr_wdata), .buf_rd(buf_rd), .irq_clr(irq_clr),
    .ovf_clr(ovf_clr), .sda_pull(sda_pull), .scl_hold(scl_hold),
    .rx_buf(rx_buf), .buf_full(buf_full), .ovf(ovf), .irq(irq),
    .upd_addr(upd_addr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1;
    acked = sda_pull;
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic wr_addr(input logic [7:0] v);
    addr_wdata = v; addr_wr = 1'b1; tick(1);
    addr_wr = 1'b0; tick(2);
  endtask

  task automatic drain();
    buf_rd = 1'b1; irq_clr = 1'b1; tick(1);
    buf_rd = 1'b0; irq_clr = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] own [2] = '{8'hA4, 8'h3F};
    logic [7:0] lows [3] = '{8'h00, 8'h5B, 8'hFF};
    tick(3);
    chk("R1 reset pull", int'(sda_pull), 0);
    chk("R1 reset hold", int'(scl_hold), 0);
    chk("R1 reset flags", int'({buf_full, ovf, irq, upd_addr}), 0);
    rst_n = 1'b1; tick(2);

    // R1: disabled block ignores a matching address
    wr_addr(8'hA4);
    bus_start(); send(8'hA4, ak); tick(2);
    chk("R1 disabled ack", int'(ak), 0);
    chk("R1 disabled bf", int'(buf_full), 0);
    bus_stop();

    enable = 1'b1; tick(2);
    // R2 R3 R4 R6: 7-bit sweep over every byte for two addresses
    foreach (own[k]) begin
      wr_addr(own[k]);
      for (int s = 0; s < 256; s++) begin
        bit exp;
        exp = (s / 2) == (int'(own[k]) / 2);
        bus_start(); send(8'(s), ak); tick(2);
        chk("R2/R4 ack", int'(ak), int'(exp));
        chk("R2/R4 buf_full", int'(buf_full), int'(exp));
        chk("R3 irq", int'(irq), int'(exp));
        if (exp) chk("R2 rx_buf", int'(rx_buf), s);
        drain();
        if (exp) chk("R6 buf_rd clears", int'(buf_full), 0);
        bus_stop();
      end
    end

    // R5: match while buffer still full
    wr_addr(8'hA4);
    bus_start(); send(8'hA4, ak); bus_stop();
    bus_start(); send(8'hA5, ak); tick(2);
    chk("R5 nack", int'(ak), 0);
    chk("R5 ovf set", int'(ovf), 1);
    chk("R5 rx_buf kept", int'(rx_buf), 8'hA4);
    bus_stop(); drain();
    bus_start(); send(8'hA5, ak);
    chk("R5 ovf blocks", int'(ak), 0);
    bus_stop();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(2);
    chk("R6 ovf_clr", int'(ovf), 0);
    bus_start(); send(8'hA5, ak); tick(2);
    chk("R5 accepted after clear", int'(ak), 1);
    bus_stop(); drain();

    // 10-bit sequences
    ten_bit = 1'b1;
    for (int hi = 0; hi < 4; hi++) begin
      foreach (lows[j]) begin
        logic [7:0] hdr, lo;
        hdr = 8'hF0 | 8'(hi * 2);
        lo  = lows[j];
        wr_addr(hdr);
        // R7: read header without write sequence is refused
        bus_start(); send(hdr | 8'h01, ak);
        chk("R7 read header first nack", int'(ak), 0);
        bus_stop();
        // R7: other A9:A8 refused
        bus_start(); send(hdr ^ 8'h02, ak);
        chk("R7 wrong hi nack", int'(ak), 0);
        bus_stop();
        bus_start(); send(hdr, ak); tick(2);
        chk("R7 header ack", int'(ak), 1);
        chk("R7 irq", int'(irq), 1);
        chk("R7 upd", int'(upd_addr), 1);
        chk("R7 hold", int'(scl_hold), 1);
        drain(); tick(H);
        chk("R7 hold kept", int'(scl_hold), 1);
        wr_addr(lo);
        chk("R8 release", int'({scl_hold, upd_addr}), 0);
        send(lo, ak); tick(2);
        chk("R8 low ack", int'(ak), 1);
        chk("R9 rx_buf", int'(rx_buf), int'(lo));
        chk("R9 flags", int'({irq, buf_full, upd_addr, scl_hold}), 4'hF);
        drain();
        wr_addr(hdr);
        chk("R9 release", int'({scl_hold, upd_addr}), 0);
        bus_start(); send(hdr | 8'h01, ak); tick(2);
        chk("R10 read ack", int'(ak), 1);
        chk("R10 flags", int'({irq, buf_full, upd_addr, scl_hold}), 4'hC);
        drain(); bus_stop();
        // R11: progress gone after STOP
        bus_start(); send(hdr | 8'h01, ak);
        chk("R11 read after stop nack", int'(ak), 0);
        bus_stop();
        // R8: wrong low byte refused
        bus_start(); send(hdr, ak); drain();
        wr_addr(lo);
        send(lo ^ 8'h01, ak); tick(2);
        chk("R8 wrong low nack", int'(ak), 0);
        chk("R8 wrong low no upd", int'(upd_addr), 0);
        bus_stop();
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule